// File: doc/BRIEF.md
# Ordered-Issue Register Hazard Arbiter

This block gives permission to start execution to a group of instruction slots that issue together. The result must be the same as running the instructions one after another in program order. Each slot supplies the set of registers its instruction reads and the set it writes. It also supplies a pulse when it has finished placing its marks and a pulse when it has finished executing. For every slot, the block drives a go signal that says the slot may start.

The hazard check does not compare tags. Each architectural register has its own ripple chain, and one more chain carries control. Every chain starts at logic 1 and runs through the slots from the earliest instruction to the latest. A slot that holds a register open forces 0 on that register's chain for every slot after it. A slot passes the chain through unchanged while it does not hold the register. The control chain is held open by a slot from the start of the issue cycle until that slot has placed its marks. A later slot therefore learns that every earlier slot has declared its registers. Reads are marked as well as writes, so two slots that use the same register in any way run in program order.

Top module: `issue_chain_arbiter`

## Requirements
- R1: A slot that has marked and is reached by an all-ones control chain and all-ones chains for its marked registers raises go on the cycle after its mark_done edge. Slot 0 sees constant ones, so it raises go as soon as it has marked.
- R2: A cycle_start pulse clears all marks and executing state in every slot, so every go bit is 0 after that edge. It also opens the control chain of each slot whose valid bit is 1 at that edge.
- R3: A slot whose valid bit is 0 at cycle_start places no marks and never holds its control chain open. Its mark_done is ignored, its go stays 0, and it never blocks a later slot.
- R4: No slot raises go while an earlier valid slot has not yet marked.
- R5: A slot stays blocked while any earlier slot that has not finished marked a register this slot reads. This applies even when the earlier slot only reads that register.
- R6: A slot that writes a register also waits until no earlier unfinished slot has marked that register.
- R7: Slots whose marked registers do not overlap with those of earlier unfinished slots raise go together in the same cycle.
- R8: Once go is raised, it stays high until a finished pulse, which drops go on the next edge. Finishing releases that slot's marks, so later slots waiting on those registers may go from that edge.
- R9: A finished pulse on a slot whose go is 0 has no effect.
- R10: While rst_n is low, every go bit is 0. The reset is applied asynchronously and released synchronously through two flops.
- R11: A mark_done pulse on a slot whose control chain is already closed has no effect. Marks are captured only once per issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Start-of-issue-cycle pulse |
| slot_valid | input | NUM_SLOTS | Slot holds an instruction, sampled at cycle_start |
| slot_src_mask | input | NUM_SLOTS*NUM_REGS | Registers read, slot i at bits [i*NUM_REGS +: NUM_REGS] |
| slot_dst_mask | input | NUM_SLOTS*NUM_REGS | Registers written, same layout |
| slot_mark_done | input | NUM_SLOTS | Decode complete, capture marks |
| slot_finished | input | NUM_SLOTS | Execution complete, release marks |
| slot_go | output | NUM_SLOTS | Slot may execute; bit 0 is the earliest instruction |

## Verification
Every go bit depends only on registered marks. A wrong bit in an open mask or control flag therefore shows on slot_go on the clock after the stimulus. A stale mark blocks a later slot forever. A lost mark lets a later slot start in the same cycle as an earlier slot that uses the same register. The bench compares the whole go vector with an ordered reference model after every edge, so such faults are reported within one cycle.

// File: rtl/issue_chain_pkg.sv
package issue_chain_pkg;
  localparam int unsigned DEF_SLOTS = 6;
  localparam int unsigned DEF_REGS  = 32;
endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/chain_ripple.sv
module chain_ripple #(
  parameter int unsigned SLOTS = 6,
  parameter int unsigned WIDTH = 32
) (
  input  logic [SLOTS*WIDTH-1:0] open_flat,
  output logic [SLOTS*WIDTH-1:0] arrive_flat
);
  logic [WIDTH-1:0] link [SLOTS+1];

  assign link[0] = '1;

  for (genvar s = 0; s < SLOTS; s++) begin : g_stage
    assign arrive_flat[s*WIDTH +: WIDTH] = link[s];
    assign link[s+1] = link[s] & ~open_flat[s*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cycle_start,
  input  logic                valid,
  input  logic                mark_done,
  input  logic                finished,
  input  logic [NUM_REGS-1:0] src_mask,
  input  logic [NUM_REGS-1:0] dst_mask,
  input  logic [NUM_REGS-1:0] reg_arrive,
  input  logic                ctrl_arrive,
  output logic [NUM_REGS-1:0] open_mask,
  output logic                ctrl_open,
  output logic                go
);
  logic [NUM_REGS-1:0] open_q, open_d;
  logic                ctrl_q, ctrl_d;
  logic                act_q, act_d;
  logic                exec_q, exec_d;
  logic                ready;
  logic                state_en;

  assign ready = ctrl_arrive && ((reg_arrive & open_q) == open_q);
  assign go    = act_q && (exec_q || ready);

  assign state_en = cycle_start || (mark_done && ctrl_q) || (finished && go) || (go && !exec_q);

  always_comb begin
    open_d = open_q;
    ctrl_d = ctrl_q;
    act_d  = act_q;
    exec_d = exec_q;
    if (cycle_start) begin
      open_d = '0;
      ctrl_d = valid;
      act_d  = 1'b0;
      exec_d = 1'b0;
    end else if (mark_done && ctrl_q) begin
      open_d = src_mask | dst_mask;
      ctrl_d = 1'b0;
      act_d  = 1'b1;
    end else if (finished && go) begin
      open_d = '0;
      act_d  = 1'b0;
      exec_d = 1'b0;
    end else if (go) begin
      exec_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      ctrl_q <= 1'b0;
      act_q  <= 1'b0;
      exec_q <= 1'b0;
    end else if (state_en) begin
      open_q <= open_d;
      ctrl_q <= ctrl_d;
      act_q  <= act_d;
      exec_q <= exec_d;
    end
  end

  assign open_mask = open_q;
  assign ctrl_open = ctrl_q;

  // R8
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !finished && !cycle_start) |=> go);

  // R8
  finish_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && finished && !cycle_start) |=> (!go && open_mask == '0));

  // R11
  mark_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_open && !cycle_start && !(finished && go)) |=> $stable(open_mask));
endmodule

// File: rtl/issue_chain_arbiter.sv
module issue_chain_arbiter
  import issue_chain_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_SLOTS,
  parameter int unsigned NUM_REGS  = DEF_REGS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cycle_start,
  input  logic [NUM_SLOTS-1:0]          slot_valid,
  input  logic [NUM_SLOTS*NUM_REGS-1:0] slot_src_mask,
  input  logic [NUM_SLOTS*NUM_REGS-1:0] slot_dst_mask,
  input  logic [NUM_SLOTS-1:0]          slot_mark_done,
  input  logic [NUM_SLOTS-1:0]          slot_finished,
  output logic [NUM_SLOTS-1:0]          slot_go
);
  localparam int unsigned FLAT = NUM_SLOTS * NUM_REGS;

  logic            rst_n_int;
  logic [FLAT-1:0] reg_open_flat;
  logic [FLAT-1:0] reg_arrive_flat;
  logic [NUM_SLOTS-1:0] ctrl_open_vec;
  logic [NUM_SLOTS-1:0] ctrl_arrive_vec;

  reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  chain_ripple #(.SLOTS(NUM_SLOTS), .WIDTH(NUM_REGS)) u_reg_chain (
    .open_flat   (reg_open_flat),
    .arrive_flat (reg_arrive_flat)
  );

  chain_ripple #(.SLOTS(NUM_SLOTS), .WIDTH(1)) u_ctrl_chain (
    .open_flat   (ctrl_open_vec),
    .arrive_flat (ctrl_arrive_vec)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    slot_tracker #(.NUM_REGS(NUM_REGS)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .cycle_start (cycle_start),
      .valid       (slot_valid[s]),
      .mark_done   (slot_mark_done[s]),
      .finished    (slot_finished[s]),
      .src_mask    (slot_src_mask[s*NUM_REGS +: NUM_REGS]),
      .dst_mask    (slot_dst_mask[s*NUM_REGS +: NUM_REGS]),
      .reg_arrive  (reg_arrive_flat[s*NUM_REGS +: NUM_REGS]),
      .ctrl_arrive (ctrl_arrive_vec[s]),
      .open_mask   (reg_open_flat[s*NUM_REGS +: NUM_REGS]),
      .ctrl_open   (ctrl_open_vec[s]),
      .go          (slot_go[s])
    );
  end

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    cycle_start |=> (slot_go == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (slot_go == '0));

  for (genvar j = 1; j < NUM_SLOTS; j++) begin : g_later
    for (genvar i = 0; i < j; i++) begin : g_earlier
      // R4
      ctrl_order_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        slot_go[j] |-> !ctrl_open_vec[i]);
      // R5
      reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        slot_go[j] |-> ((reg_open_flat[i*NUM_REGS +: NUM_REGS] &
                         reg_open_flat[j*NUM_REGS +: NUM_REGS]) == '0));
    end
  end
endmodule

// File: tb/issue_chain_arbiter_tb.sv
module issue_chain_arbiter_tb;
  localparam int S = 6;
  localparam int R = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic cs;
  logic [S-1:0] val, mk, fin;
  logic [S*R-1:0] src, dst;
  logic [S-1:0] go;

  int checks = 0;
  int fails  = 0;

  logic [R-1:0] m_open [S];
  bit m_ctrl [S];
  bit m_act  [S];
  bit m_exec [S];

  always #5 clk = ~clk;

  issue_chain_arbiter #(.NUM_SLOTS(S), .NUM_REGS(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cs), .slot_valid(val),
    .slot_src_mask(src), .slot_dst_mask(dst), .slot_mark_done(mk),
    .slot_finished(fin), .slot_go(go)
  );

  function automatic logic [S-1:0] model_go();
    logic [R-1:0] ch = '1;
    bit c = 1'b1;
    logic [S-1:0] g;
    for (int i = 0; i < S; i++) begin
      bit rdy;
      rdy = c && ((ch & m_open[i]) == m_open[i]);
      g[i] = m_act[i] && (m_exec[i] || rdy);
      ch = ch & ~m_open[i];
      c = c && !m_ctrl[i];
    end
    return g;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < S; i++) begin
      m_open[i] = '0; m_ctrl[i] = 0; m_act[i] = 0; m_exec[i] = 0;
    end
  endtask

  task automatic check(input string tag, input logic [S-1:0] exp);
    checks++;
    if (go !== exp) begin
      fails++;
      $display("FAIL %s: go=%b expected %b", tag, go, exp);
    end
  endtask

  task automatic idle_inputs();
    cs = 0; mk = '0; fin = '0;
  endtask

  task automatic step(input string tag);
    logic [S-1:0] g;
    g = model_go();
    @(posedge clk);
    for (int i = 0; i < S; i++) begin
      if (cs) begin
        m_open[i] = '0; m_ctrl[i] = val[i]; m_act[i] = 0; m_exec[i] = 0;
      end else if (mk[i] && m_ctrl[i]) begin
        m_open[i] = src[i*R +: R] | dst[i*R +: R];
        m_ctrl[i] = 0; m_act[i] = 1;
      end else if (fin[i] && g[i]) begin
        m_open[i] = '0; m_act[i] = 0; m_exec[i] = 0;
      end else if (g[i]) begin
        m_exec[i] = 1;
      end
    end
    @(negedge clk);
    check(tag, model_go());
    idle_inputs();
  endtask

  task automatic set_slot(input int s, input logic [R-1:0] rd, input logic [R-1:0] wr);
    src[s*R +: R] = rd;
    dst[s*R +: R] = wr;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: go=%b expected run end", go);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    model_clear();
    rst_n = 0; val = '0; src = '0; dst = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R10 reset", '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10 after release", '0);

    // slot0: rd r1 wr r2; slot1 rd r2; slot2 rd r1; slot3 rd r10 wr r9
    // slot4 wr r1; slot5 rd r20 wr r21
    set_slot(0, 32'h2, 32'h4);
    set_slot(1, 32'h4, 32'h0);
    set_slot(2, 32'h2, 32'h0);
    set_slot(3, 32'h400, 32'h200);
    set_slot(4, 32'h0, 32'h2);
    set_slot(5, 32'h100000, 32'h200000);
    val = '1; cs = 1;
    step("R2 start");
    mk = 6'b111110;
    step("R4 slot0 unmarked");
    check("R4 all held", '0);
    mk = 6'b000001;
    step("R1 R7 slot0 marks");
    check("R7 independent together", 6'b101001);
    mk = 6'b000001;
    step("R11 second mark ignored");
    fin = 6'b000010;
    step("R9 finish while blocked");
    check("R9 no effect", 6'b101001);
    step("R8 hold");
    check("R8 held", 6'b101001);
    fin = 6'b000001;
    step("R8 finish slot0");
    check("R5 R8 release", 6'b101110);
    fin = 6'b000100;
    step("R6 writer after reader");
    check("R6 writer waits then goes", 6'b111010);
    cs = 1; val = 6'b111110;
    step("R2 restart mid-run");
    check("R2 cleared", '0);
    mk = 6'b000011;
    step("R3 invalid slot0");
    check("R3 slot1 not blocked", 6'b000010);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 24) == 0) begin
        cs = 1;
        for (int i = 0; i < S; i++) val[i] = ($urandom_range(0, 4) != 0);
      end else begin
        logic [S-1:0] g;
        g = model_go();
        for (int i = 0; i < S; i++) begin
          mk[i]  = ($urandom_range(0, 1) == 1);
          fin[i] = g[i] ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 7) == 0);
          set_slot(i, R'(1) << $urandom_range(0, 7), R'(1) << $urandom_range(0, 7));
        end
      end
      step("R5 R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule